// File: doc/BRIEF.md
# Floating-Point Four-Mode Rounding Stage

This block is the last step of a single-precision arithmetic datapath. It takes a result that has already been normalized: a sign, a biased exponent, a 24-bit significand with its leading one present, and three extra low-order bits (guard, round, sticky). It uses a 2-bit mode code to decide whether the significand is bumped by one unit in the last place. It applies that bump and packs the 32-bit result.

When the bump carries out of the significand, the significand becomes 1.000…0 and the exponent goes up by one. If that pushes the exponent to the reserved all-ones value, the output is an infinity and an overflow flag is raised. An inexact flag reports that any of the three extra bits was set. The stage is purely combinational, with no clock and no reset.

Top module: `fp_round_unit`

## Requirements
- R1: In mode 00 (nearest, ties to even), the significand is incremented when the guard bit is 1 and the round or sticky bit is 1.
- R2: In mode 00 with guard = 1 and round = sticky = 0 (an exact tie), the significand is incremented only when its least significant bit (input significand bit 0) is 1, so the result is even. With guard = 0 it is never incremented.
- R3: In mode 01 (toward zero), the significand is never incremented. The exponent and fraction pass through unchanged.
- R4: In mode 10 (toward +infinity), the significand is incremented exactly when the sign is 0 and at least one of guard, round, sticky is 1.
- R5: In mode 11 (toward -infinity), the significand is incremented exactly when the sign is 1 and at least one of guard, round, sticky is 1.
- R6: When the increment carries out of an all-ones significand, the output fraction is all zeros and the output exponent is the input exponent plus one.
- R7: `inexact` is 1 exactly when at least one of guard, round, sticky is 1.
- R8: When the carry takes the exponent to 255, the result is infinity of the input sign: exponent field all ones, fraction zero, and `overflow` = 1. Otherwise `overflow` = 0.
- R9: The result packs the sign in bit 31, the exponent in bits 30:23 and the fraction in bits 22:0. The leading one of the significand is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value (1 = negative) |
| exp_i | input | 8 | Biased exponent, 1 to 254 |
| sig_i | input | 24 | Normalized significand, bit 23 is the leading one |
| grs_i | input | 3 | Guard (bit 2), round (bit 1), sticky (bit 0) |
| mode_i | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| result_o | output | 32 | Packed rounded result |
| inexact_o | output | 1 | Any discarded bit was set |
| overflow_o | output | 1 | Rounding carry reached the reserved exponent |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. With these widths the all-ones significand and the exponent value 254 are real corner points, so the carry-into-exponent path and the overflow-to-infinity path are hit by directed vectors. A random mix is weighted toward those values as well. Every mode is driven with both signs and all eight guard/round/sticky patterns, including the exact ties with an odd and an even last bit.

// File: rtl/fp_round_pkg.sv
// Package: shared rounding-mode encoding for the rounding stage.
package fp_round_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;
endpackage

// File: rtl/round_decide.sv
// round_decide: decides whether the significand gets a one-ulp bump.
// Assumes the guard/round/sticky bits sit directly below the significand LSB.
module round_decide
    import fp_round_pkg::*;
(
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic [2:0] grs_i,
    input  logic [1:0] mode_i,
    output logic       bump_o,
    output logic       inexact_o
);
    logic   g_b, rs_any, any_b;
    rmode_e mode;

    // Split the extra bits and classify the mode.
    always_comb begin
        mode      = rmode_e'(mode_i);
        g_b       = grs_i[2];
        rs_any    = grs_i[1] | grs_i[0];
        any_b     = g_b | rs_any;
        inexact_o = any_b;
    end

    // Select the increment rule for the active mode.
    always_comb begin
        unique case (mode)
            RM_NEAR_EVEN: bump_o = g_b & (rs_any | lsb_i);
            RM_TO_ZERO:   bump_o = 1'b0;
            RM_TO_POS:    bump_o = ~sign_i & any_b;
            RM_TO_NEG:    bump_o = sign_i & any_b;
            default:      bump_o = 1'b0;
        endcase
    end

    // Directed modes never bump a value of the opposite sign.
    always_comb begin
        assert_pos_mode_sign_R4: assert (!(mode_i == 2'b10 && sign_i && bump_o))
            else $error("bump on negative value toward +inf");
        assert_neg_mode_sign_R5: assert (!(mode_i == 2'b11 && !sign_i && bump_o))
            else $error("bump on positive value toward -inf");
    end
endmodule

// File: rtl/sig_incr.sv
// sig_incr: adds the rounding bump to the significand and renormalizes.
// Assumes the input significand has its leading one set.
module sig_incr #(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W-1:0] sig_i,
    input  logic             bump_i,
    output logic [SIG_W-2:0] frac_o,
    output logic             carry_o
);
    logic [SIG_W:0] sum;

    // Increment the significand and fold a carry back to 1.000...0.
    always_comb begin
        sum     = {1'b0, sig_i} + {{SIG_W{1'b0}}, bump_i};
        carry_o = sum[SIG_W];
        frac_o  = carry_o ? '0 : sum[SIG_W-2:0];
    end

    // A carry can only come from an all-ones significand.
    always_comb begin
        assert_carry_source_R6: assert (!carry_o || (&sig_i))
            else $error("carry from a significand that is not all ones");
    end
endmodule

// File: rtl/exp_pack.sv
// exp_pack: applies the renormalization carry to the exponent and packs the word.
// Assumes the input exponent is below the reserved all-ones value.
module exp_pack #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic             sign_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic             carry_i,
    input  logic [MAN_W-1:0] frac_i,
    output logic [EXP_W+MAN_W:0] result_o,
    output logic             overflow_o
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    logic [EXP_W-1:0] exp_next;

    // Bump the exponent on carry and flag the reserved value.
    always_comb begin
        exp_next   = exp_i + {{(EXP_W-1){1'b0}}, carry_i};
        overflow_o = carry_i && (exp_next == EXP_MAX);
    end

    // Pack sign, exponent and fraction; an overflow becomes signed infinity.
    always_comb begin
        if (overflow_o) result_o = {sign_i, EXP_MAX, {MAN_W{1'b0}}};
        else            result_o = {sign_i, exp_next, frac_i};
    end
endmodule

// File: rtl/fp_round_unit.sv
// fp_round_unit: combinational four-mode rounding of a normalized significand.
// Assumes exp_i in 1..2^EXP_W-2 and sig_i with its leading one set.
module fp_round_unit #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 sign_i,
    input  logic [EXP_W-1:0]     exp_i,
    input  logic [MAN_W:0]       sig_i,
    input  logic [2:0]           grs_i,
    input  logic [1:0]           mode_i,
    output logic [EXP_W+MAN_W:0] result_o,
    output logic                 inexact_o,
    output logic                 overflow_o
);
    localparam int SIG_W = MAN_W + 1;
    localparam int WORD_W = 1 + EXP_W + MAN_W;

    logic             bump, carry;
    logic [MAN_W-1:0] frac_r;

    round_decide u_decide (
        .sign_i   (sign_i),
        .lsb_i    (sig_i[0]),
        .grs_i    (grs_i),
        .mode_i   (mode_i),
        .bump_o   (bump),
        .inexact_o(inexact_o)
    );

    sig_incr #(.SIG_W(SIG_W)) u_incr (
        .sig_i  (sig_i),
        .bump_i (bump),
        .frac_o (frac_r),
        .carry_o(carry)
    );

    exp_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
        .sign_i    (sign_i),
        .exp_i     (exp_i),
        .carry_i   (carry),
        .frac_i    (frac_r),
        .result_o  (result_o),
        .overflow_o(overflow_o)
    );

    // Port-level checks on mode, exactness and overflow behaviour.
    always_comb begin
        assert_no_overflow_R8: assert (!overflow_o ||
                ((&result_o[WORD_W-2:MAN_W]) && (result_o[MAN_W-1:0] == '0)))
            else $error("overflow without infinity encoding");
        assert_trunc_pass_R3: assert (mode_i != 2'b01 ||
                (result_o[WORD_W-2:0] == {exp_i, sig_i[MAN_W-1:0]}))
            else $error("toward-zero result differs from input");
        assert_exact_pass_R7: assert (inexact_o ||
                (result_o[WORD_W-2:0] == {exp_i, sig_i[MAN_W-1:0]}))
            else $error("exact input altered");
        assert_sign_kept_R9: assert (result_o[WORD_W-1] == sign_i)
            else $error("sign not carried to result");
    end
endmodule

// File: tb/fp_round_unit_tb.sv
module fp_round_unit_tb_top;
    logic        clk = 1'b0;
    logic        sign_i;
    logic [7:0]  exp_i;
    logic [23:0] sig_i;
    logic [2:0]  grs_i;
    logic [1:0]  mode_i;
    logic [31:0] result_o;
    logic        inexact_o, overflow_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fp_round_unit dut_i (
        .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i), .grs_i(grs_i),
        .mode_i(mode_i), .result_o(result_o), .inexact_o(inexact_o),
        .overflow_o(overflow_o)
    );

    // Behavioural reference built from the requirement text with integers.
    function automatic void model(input bit s, input int e, input longint m,
                                  input int grs, input int md,
                                  output logic [31:0] res, output bit inx, output bit ovf);
        bit g = grs[2];
        bit r = grs[1];
        bit st = grs[0];
        bit any = g || r || st;
        bit up;
        longint total;
        int ee = e;
        case (md)
            0: up = g && (r || st || (m % 2 == 1));
            1: up = 0;
            2: up = !s && any;
            default: up = s && any;
        endcase
        total = m + (up ? 1 : 0);
        if (total >= 64'd16777216) begin
            total = total / 2;
            ee = ee + 1;
        end
        inx = any;
        ovf = (ee == 255);
        if (ovf) res = {s, 8'hFF, 23'd0};
        else     res = {s, ee[7:0], total[22:0]};
    endfunction

    task automatic apply(input string tag, input bit s, input int e, input int m,
                         input int grs, input int md);
        logic [31:0] xr;
        bit xi, xo;
        @(posedge clk);
        sign_i = s; exp_i = e[7:0]; sig_i = m[23:0]; grs_i = grs[2:0]; mode_i = md[1:0];
        model(s, e, longint'(m), grs, md, xr, xi, xo);
        @(negedge clk);
        n_checks++;
        if (result_o !== xr || inexact_o !== xi || overflow_o !== xo) begin
            n_fail++;
            $display("FAIL %s: got res=%h inx=%b ovf=%b expected res=%h inx=%b ovf=%b",
                     tag, result_o, inexact_o, overflow_o, xr, xi, xo);
        end
    endtask

    localparam int ONE  = 24'h800000;
    localparam int ALL1 = 24'hFFFFFF;

    initial begin
        sign_i = 0; exp_i = 8'd127; sig_i = ONE[23:0]; grs_i = 0; mode_i = 0;
        // Exact input passes unchanged in every mode (R7, R9).
        for (int md = 0; md < 4; md++) apply("R9", 0, 127, ONE, 0, md);
        // R1: above half rounds up in nearest mode.
        apply("R1", 0, 130, 24'h800002, 3'b110, 0);
        apply("R1", 1, 130, 24'h800002, 3'b101, 0);
        // R2: ties go to even.
        apply("R2", 0, 130, 24'h800001, 3'b100, 0);
        apply("R2", 0, 130, 24'h800002, 3'b100, 0);
        apply("R2", 1, 100, 24'h800003, 3'b011, 0);
        // R3: toward zero truncates.
        apply("R3", 0, 140, 24'h8ABCDF, 3'b111, 1);
        apply("R3", 1, 254, ALL1, 3'b111, 1);
        // R4 / R5: directed modes by sign.
        apply("R4", 0, 120, 24'h800010, 3'b001, 2);
        apply("R4", 1, 120, 24'h800010, 3'b111, 2);
        apply("R5", 1, 120, 24'h800010, 3'b001, 3);
        apply("R5", 0, 120, 24'h800010, 3'b111, 3);
        // R6: carry renormalizes into exponent.
        apply("R6", 0, 127, ALL1, 3'b110, 0);
        apply("R6", 1, 3, ALL1, 3'b010, 3);
        // R8: carry at top exponent gives infinity.
        apply("R8", 0, 254, ALL1, 3'b100, 0);
        apply("R8", 1, 254, ALL1, 3'b001, 3);
        apply("R8", 0, 254, ALL1, 3'b001, 2);
        apply("R8", 0, 254, 24'hFFFFFE, 3'b100, 0);
        // R7: inexact for each single extra bit.
        apply("R7", 0, 50, 24'h800004, 3'b001, 1);
        apply("R7", 0, 50, 24'h800004, 3'b010, 1);
        // Random mix weighted toward corner values.
        for (int i = 0; i < 3000; i++) begin
            int md = $urandom_range(0, 3);
            int e  = ($urandom_range(0, 3) == 0) ? 254 : $urandom_range(1, 254);
            int m  = ($urandom_range(0, 3) == 0) ? ALL1 : (ONE | $urandom_range(0, 24'h7FFFFF));
            string tg = (md == 0) ? "R1" : (md == 1) ? "R3" : (md == 2) ? "R4" : "R5";
            apply(tg, $urandom_range(0, 1), e, m, $urandom_range(0, 7), md);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule